// File: doc/BRIEF.md
# Interworking Branch Next-PC Unit

This block holds the program counter of a core that can run in several instruction-set states and works out the counter's next value every clock. The current state is kept beside the address as a two-bit field: one bit marks the compact encoding (T) and one marks the extended mode (J). With both set, the core is in the enhanced-compact state. When no branch is taken, the counter steps past the current instruction. A taken branch comes in one of three kinds. A regular branch aligns the target to the current state's instruction size. An interworking branch reads the target's two low bits to pick the next state. A conditional variant interworks only from the base state and acts as a regular branch in every other state.

The block also gives the address that an instruction sees when it reads the PC, which runs ahead of the fetch address. When the target of an interworking branch cannot be used, the block raises a one-cycle flag. A target that is illegal in the enhanced-compact state raises an error flag and leaves the counter where it was. A target that is misaligned in any other state raises a warning flag, and the branch still goes ahead. Deciding whether a branch is taken, fetching instructions and exception vectors all belong to other blocks.

Top module: `ipc_next_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, the address output is RESET_ADDR (default 0), the state output is RESET_STATE (default 2'b00, base), and both flags are low.
- R2: The read-PC output equals the address plus 4 when state bit 0 (T) is set and plus 8 when it is clear, wrapping modulo 2^ADDR_W.
- R3: On a clock edge with the valid strobe low, or with kind 2'b11, the address steps by 2 when T is set and by 4 when T is clear. The step wraps, the state does not change and both flags stay low.
- R4: A regular branch (kind 2'b00) loads the target with bit 0 cleared when T is set, or with bits 1:0 cleared when T is clear. The state does not change.
- R5: An interworking branch (kind 2'b01) taken in the enhanced-compact state (2'b11) with target bit 0 set loads the target with bit 0 cleared and keeps the state.
- R6: An interworking branch taken in the enhanced-compact state with target bit 0 clear leaves both address and state unchanged and raises the error flag.
- R7: An interworking branch taken in any state other than 2'b11 with target bit 0 set moves to the compact state (2'b01) and loads the target with bit 0 cleared.
- R8: An interworking branch taken in any state other than 2'b11 with target bits 1:0 equal to 2'b00 moves to the base state (2'b00) and loads the target unchanged.
- R9: An interworking branch taken in any state other than 2'b11 with target bits 1:0 equal to 2'b10 loads the target unchanged, keeps the state and raises the warning flag.
- R10: A base-only interworking branch (kind 2'b10) acts as R7 to R9 when the state is 2'b00 and as a regular branch (R4) in every other state.
- R11: Each flag is high only in the cycle right after the edge that took the offending interworking branch. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | A branch is taken at this edge |
| br_kind_i | input | 2 | 00 regular, 01 interworking, 10 base-only interworking, 11 no branch |
| br_target_i | input | ADDR_W | Branch target address |
| pc_addr_o | output | ADDR_W | Current PC address |
| pc_state_o | output | 2 | Current state {J, T}: 00 base, 01 compact, 11 enhanced-compact |
| read_pc_o | output | ADDR_W | PC value that an instruction reads |
| iw_err_o | output | 1 | Unusable interworking target in the enhanced-compact state |
| iw_warn_o | output | 1 | Misaligned interworking target |

## Verification
The address, the state and both flags come from registers. Each of them shows the effect of the inputs sampled at a rising edge from that edge until the next one. The read-PC output is combinational on the registered address, so it changes together with that address. The bench changes the inputs on the falling edge, lets one rising edge pass, and checks every output on the following falling edge. A flag that should be high is therefore seen in the one cycle it is due. The next vector's check also confirms that the flag has dropped again.

// File: rtl/ipc_types_pkg.sv
package ipc_types_pkg;

  typedef enum logic [1:0] {
    BK_REGULAR  = 2'b00,
    BK_IWORK    = 2'b01,
    BK_BASE_IW  = 2'b10,
    BK_NONE     = 2'b11
  } br_kind_e;

  // State field is {J, T}
  localparam logic [1:0] ST_BASE    = 2'b00;
  localparam logic [1:0] ST_COMPACT = 2'b01;
  localparam logic [1:0] ST_ENHC    = 2'b11;

endpackage

// File: rtl/ipc_seq_step.sv
module ipc_seq_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              t_bit_i,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [ADDR_W-1:0] read_pc_o
);

  // Size of one instruction in the current state
  function automatic logic [ADDR_W-1:0] insn_size(input logic t);
    return t ? ADDR_W'(2) : ADDR_W'(4);
  endfunction

  // Pipeline offset of the value an instruction reads
  function automatic logic [ADDR_W-1:0] read_offset(input logic t);
    return t ? ADDR_W'(4) : ADDR_W'(8);
  endfunction

  assign seq_addr_o = addr_i + insn_size(t_bit_i);
  assign read_pc_o  = addr_i + read_offset(t_bit_i);

endmodule

// File: rtl/ipc_regular_br.sv
module ipc_regular_br #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] target_i,
  input  logic              t_bit_i,
  output logic [ADDR_W-1:0] addr_o
);

  // Low bits to drop for the current state's alignment
  function automatic logic [ADDR_W-1:0] align_mask(input logic t);
    return t ? ADDR_W'(1) : ADDR_W'(3);
  endfunction

  assign addr_o = target_i & ~align_mask(t_bit_i);

endmodule

// File: rtl/ipc_iwork_br.sv
module ipc_iwork_br #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] target_i,
  input  logic [1:0]        state_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        state_o,
  output logic              err_o,
  output logic              warn_o
);
  import ipc_types_pkg::*;

  logic enh_state;
  assign enh_state = (state_i == ST_ENHC);

  always_comb begin
    addr_o  = target_i;
    state_o = state_i;
    err_o   = 1'b0;
    warn_o  = 1'b0;
    if (enh_state) begin
      if (target_i[0]) addr_o[0] = 1'b0;
      else             err_o     = 1'b1;
    end else if (target_i[0]) begin
      addr_o[0] = 1'b0;
      state_o   = ST_COMPACT;
    end else if (!target_i[1]) begin
      state_o   = ST_BASE;
    end else begin
      warn_o    = 1'b1;
    end
  end

endmodule

// File: rtl/ipc_next_unit.sv
module ipc_next_unit #(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] RESET_ADDR  = 32'h0,
  parameter logic [1:0]  RESET_STATE = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid_i,
  input  logic [1:0]        br_kind_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic [ADDR_W-1:0] pc_addr_o,
  output logic [1:0]        pc_state_o,
  output logic [ADDR_W-1:0] read_pc_o,
  output logic              iw_err_o,
  output logic              iw_warn_o
);
  import ipc_types_pkg::*;

  localparam logic [ADDR_W-1:0] RST_A  = ADDR_W'(RESET_ADDR);
  localparam logic [ADDR_W-1:0] STEP_T = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_addr_q;
  logic [1:0]        pc_state_q;
  logic              err_q, warn_q, seen_q;

  br_kind_e kind;
  assign kind = br_kind_e'(br_kind_i);

  // Named events used by the update logic and the assertions
  logic in_base, take_iw, take_reg, take_seq;
  assign in_base  = (pc_state_q == ST_BASE);
  assign take_iw  = br_valid_i && ((kind == BK_IWORK) || (kind == BK_BASE_IW && in_base));
  assign take_reg = br_valid_i && ((kind == BK_REGULAR) || (kind == BK_BASE_IW && !in_base));
  assign take_seq = !take_iw && !take_reg;

  logic [ADDR_W-1:0] seq_addr, reg_addr, iw_addr;
  logic [1:0]        iw_state;
  logic              iw_err, iw_warn;

  ipc_seq_step #(.ADDR_W(ADDR_W)) u_seq (
    .addr_i     (pc_addr_q),
    .t_bit_i    (pc_state_q[0]),
    .seq_addr_o (seq_addr),
    .read_pc_o  (read_pc_o)
  );

  ipc_regular_br #(.ADDR_W(ADDR_W)) u_reg (
    .target_i (br_target_i),
    .t_bit_i  (pc_state_q[0]),
    .addr_o   (reg_addr)
  );

  ipc_iwork_br #(.ADDR_W(ADDR_W)) u_iw (
    .target_i (br_target_i),
    .state_i  (pc_state_q),
    .addr_o   (iw_addr),
    .state_o  (iw_state),
    .err_o    (iw_err),
    .warn_o   (iw_warn)
  );

  logic [ADDR_W-1:0] nxt_addr;
  logic [1:0]        nxt_state;

  always_comb begin
    nxt_addr  = seq_addr;
    nxt_state = pc_state_q;
    if (take_iw) begin
      if (iw_err) begin
        nxt_addr = pc_addr_q;
      end else begin
        nxt_addr  = iw_addr;
        nxt_state = iw_state;
      end
    end else if (take_reg) begin
      nxt_addr = reg_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_addr_q  <= RST_A;
      pc_state_q <= RESET_STATE;
      err_q      <= 1'b0;
      warn_q     <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      pc_addr_q  <= nxt_addr;
      pc_state_q <= nxt_state;
      err_q      <= take_iw && iw_err;
      warn_q     <= take_iw && iw_warn;
      seen_q     <= 1'b1;
    end
  end

  assign pc_addr_o  = pc_addr_q;
  assign pc_state_o = pc_state_q;
  assign iw_err_o   = err_q;
  assign iw_warn_o  = warn_q;

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && warn_q));

  a_r11_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(!take_iw)) |-> (!err_q && !warn_q));

  a_r6_err_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && err_q) |-> (pc_addr_q == $past(pc_addr_q) && pc_state_q == $past(pc_state_q)));

  a_r9_warn_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && warn_q) |-> (pc_state_q == $past(pc_state_q)));

  a_r8_state_change_needs_iw: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && pc_state_q != $past(pc_state_q)) |-> $past(take_iw));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(take_seq)) |->
      (pc_addr_q == $past(pc_addr_q) + ($past(pc_state_q[0]) ? STEP_T : STEP_B)));

  a_r4_regular_align: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(take_reg)) |->
      (pc_state_q[0] ? (pc_addr_q[0] == 1'b0) : (pc_addr_q[1:0] == 2'b00)));

endmodule

// File: tb/sim_ipc_next_unit.sv
`timescale 1ns/1ps
module sim_ipc_next_unit;

  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, rst1_n;
  logic v0, v1;
  logic [1:0] k0, k1;
  logic [AW-1:0] t0, t1;
  logic [AW-1:0] a0, a1, r0, r1;
  logic [1:0] s0, s1;
  logic e0, e1, w0, w1;

  int n_chk = 0;
  int n_bad = 0;

  ipc_next_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid_i(v0), .br_kind_i(k0), .br_target_i(t0),
    .pc_addr_o(a0), .pc_state_o(s0), .read_pc_o(r0), .iw_err_o(e0), .iw_warn_o(w0));

  ipc_next_unit #(.ADDR_W(AW), .RESET_ADDR(32'h100), .RESET_STATE(2'b11)) u1 (
    .clk(clk), .rst_n(rst1_n), .br_valid_i(v1), .br_kind_i(k1), .br_target_i(t1),
    .pc_addr_o(a1), .pc_state_o(s1), .read_pc_o(r1), .iw_err_o(e1), .iw_warn_o(w1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rd_pc(input logic [AW-1:0] a, input logic [1:0] s);
    return s[0] ? a + 32'd4 : a + 32'd8;
  endfunction

  // {kind, target, expected addr, expected state, err, warn}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {2'b01, 32'h0000_1001, 32'h0000_1000, 2'b01, 1'b0, 1'b0},  // R7
    {2'b00, 32'h0000_2003, 32'h0000_2002, 2'b01, 1'b0, 1'b0},  // R4 compact
    {2'b10, 32'h0000_3001, 32'h0000_3000, 2'b01, 1'b0, 1'b0},  // R10 acts regular
    {2'b01, 32'h0000_0400, 32'h0000_0400, 2'b00, 1'b0, 1'b0},  // R8
    {2'b00, 32'h0000_5007, 32'h0000_5004, 2'b00, 1'b0, 1'b0},  // R4 base
    {2'b01, 32'h0000_6002, 32'h0000_6002, 2'b00, 1'b0, 1'b1},  // R9
    {2'b10, 32'h0000_7001, 32'h0000_7000, 2'b01, 1'b0, 1'b0},  // R10 interworks
    {2'b10, 32'h0000_8001, 32'h0000_8000, 2'b01, 1'b0, 1'b0},  // R10 regular
    {2'b01, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 2'b00, 1'b0, 1'b0},  // R8
    {2'b11, 32'h0000_1234, 32'h0000_0000, 2'b00, 1'b0, 1'b0}   // R3 kind none, wrap
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R7";
      1: return "R4";
      2: return "R10";
      3: return "R8";
      4: return "R4";
      5: return "R9";
      6: return "R10";
      7: return "R10";
      8: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic step0(input logic v, input logic [1:0] k, input logic [AW-1:0] t);
    v0 = v; k0 = k; t0 = t;
    @(posedge clk); @(negedge clk);
    v0 = 1'b0;
  endtask

  task automatic step1(input logic v, input logic [1:0] k, input logic [AW-1:0] t);
    v1 = v; k1 = k; t1 = t;
    @(posedge clk); @(negedge clk);
    v1 = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rst1_n = 1'b0;
    v0 = 1'b0; k0 = 2'b00; t0 = '0;
    v1 = 1'b0; k1 = 2'b00; t1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, R2 read-PC in base state
    chk("R1 addr",  64'(a0), 64'h0);
    chk("R1 state", 64'(s0), 64'h0);
    chk("R1 flags", 64'({e0, w0}), 64'h0);
    chk("R2 reset read", 64'(r0), 64'h8);

    rst_n = 1'b1;
    step0(1'b0, 2'b00, 32'h0);
    chk("R3 base step", 64'(a0), 64'h4);
    chk("R1 flags after release", 64'({e0, w0}), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] e;
      e = VEC[i];
      step0(1'b1, e[69:68], e[67:36]);
      chk({vec_tag(i), " addr"},  64'(a0), 64'(e[35:4]));
      chk({vec_tag(i), " state"}, 64'(s0), 64'(e[3:2]));
      chk("R11 err",  64'(e0), 64'(e[1]));
      chk("R11 warn", 64'(w0), 64'(e[0]));
      chk("R2 read",  64'(r0), 64'(rd_pc(e[35:4], e[3:2])));
    end

    // Compact state stepping and read-PC wrap
    step0(1'b1, 2'b01, 32'h0000_0011);
    chk("R7 addr", 64'(a0), 64'h10);
    step0(1'b0, 2'b01, 32'h0);
    chk("R3 compact step", 64'(a0), 64'h12);
    chk("R2 compact read", 64'(r0), 64'h16);
    step0(1'b1, 2'b00, 32'hFFFF_FFFF);
    chk("R4 compact align", 64'(a0), 64'hFFFF_FFFE);
    chk("R2 read wrap", 64'(r0), 64'h2);
    step0(1'b0, 2'b00, 32'h0);
    chk("R3 step wrap", 64'(a0), 64'h0);
    chk("R3 state kept", 64'(s0), 64'h1);

    // Enhanced-compact instance
    chk("R1 u1 addr",  64'(a1), 64'h100);
    chk("R1 u1 state", 64'(s1), 64'h3);
    chk("R2 u1 read",  64'(r1), 64'h104);
    rst1_n = 1'b1;
    step1(1'b0, 2'b00, 32'h0);
    chk("R3 u1 step", 64'(a1), 64'h102);
    step1(1'b1, 2'b01, 32'h0000_2000);
    chk("R6 err",   64'(e1), 64'h1);
    chk("R6 addr",  64'(a1), 64'h102);
    chk("R6 state", 64'(s1), 64'h3);
    chk("R11 no warn", 64'(w1), 64'h0);
    step1(1'b1, 2'b01, 32'h0000_3001);
    chk("R5 addr",  64'(a1), 64'h3000);
    chk("R5 state", 64'(s1), 64'h3);
    chk("R11 err drop", 64'(e1), 64'h0);
    step1(1'b1, 2'b00, 32'h0000_4003);
    chk("R4 enh addr", 64'(a1), 64'h4002);
    step1(1'b1, 2'b10, 32'h0000_5002);
    chk("R10 enh addr",  64'(a1), 64'h5002);
    chk("R10 enh state", 64'(s1), 64'h3);
    chk("R10 no err",    64'(e1), 64'h0);

    finish_run();
  end

endmodule